// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block produces the active-low reset for a host processor from three conditions: the supply, a settling delay, and a software watchdog. An external comparator reports supply health as a single digital power-good bit. While that bit is low, the reset output is held low. Once the bit goes high, reset stays low for a fixed settling interval and then releases.

After release, an optional watchdog counts clock cycles. The host restarts the count by driving a falling edge on a shared select/kick line. If no falling edge arrives within the period chosen by a 2-bit select code, the block drives reset low again for the same settling interval. It then releases reset and starts counting again from zero. A line that is stuck high and a line that is stuck low both lead to a timeout, because only falling edges count.

Top module: `supv_reset_gen`

## Requirements
- R1: While `pwr_ok_i` is 0, `rst_n_o` is 0 in the same cycle. A `rst_n_o` value of 0 means reset is active.
- R2: `rst_n_o` becomes 1 after `pwr_ok_i` has been 1 for `HOLD_CYCLES` consecutive rising edges. Any cycle with `pwr_ok_i` at 0 restarts this count, including a cycle during the hold.
- R3: `kick_i` passes through a two-flop synchronizer that is preset high while the supply is low. A high-to-low change of `kick_i` before rising edge k restarts the watchdog count at edge k+2. Falling edges that arrive at least once per period keep reset released.
- R4: `wd_sel_i` encoding: 2'b00 selects `WD_CYC_0`, 2'b01 selects `WD_CYC_1`, 2'b10 selects `WD_CYC_2`, and 2'b11 disables the watchdog.
- R5: With the watchdog running and no restart, `rst_n_o` goes to 0 on exactly the P-th rising edge after reset release or after the last restart, where P is the selected period. This holds whether `kick_i` is held high or held low.
- R6: After a watchdog timeout, `rst_n_o` stays 0 for `HOLD_CYCLES` rising edges and then returns to 1. The watchdog then counts again from zero and times out P edges later if no restart arrives.
- R7: When `wd_en_i` is 0 or `wd_sel_i` is 2'b11, no timeout occurs and `rst_n_o` stays 1 for as long as the supply is good.
- R8: While reset is active, for either cause, the watchdog count is held at zero and falling edges on `kick_i` have no effect on the next timeout.
- R9: If a restart and an expiry fall on the same rising edge, the restart wins and reset stays released.
- R10: If `wd_sel_i` switches to a period that the running count has already reached, the watchdog times out on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Supervisor clock |
| pwr_ok_i | input | 1 | Supply-above-trip indication, synchronous to clk_i; 0 also clears all state |
| kick_i | input | 1 | Shared select/kick line; its falling edges restart the watchdog |
| wd_en_i | input | 1 | Watchdog enable |
| wd_sel_i | input | 2 | Timeout period select (see R4) |
| rst_n_o | output | 1 | Active-low reset to the host |

## Verification
Two pairs of events can land on the same clock edge. A synchronized kick edge can meet the watchdog expiry, and a supply drop can meet a running hold or a timeout. To hit the first pair, the bench counts edges from the observed release and drops `kick_i` so that its restart lands exactly on the expiry edge. It then repeats the test one cycle later, so the restart arrives after the expiry. Each case is judged by how many edges pass until reset falls: one extra period in the first case, two edges in the second. The other pair comes up in a seeded random phase, where supply drops, selector changes and kick toggles are mixed. That phase is compared cycle by cycle against a bench model of the requirements.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_SEL_A   = 2'b00,
    WD_SEL_B   = 2'b01,
    WD_SEL_C   = 2'b10,
    WD_SEL_OFF = 2'b11
  } wd_sel_e;

  // Largest of three periods, used to size the watchdog counter.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Period in cycles for a select code; zero for the disabling code.
  function automatic logic [31:0] period_for(input logic [1:0] sel, input logic [31:0] p0,
                                             input logic [31:0] p1, input logic [31:0] p2);
    case (wd_sel_e'(sel))
      WD_SEL_A: return p0;
      WD_SEL_B: return p1;
      WD_SEL_C: return p2;
      default:  return 32'd0;
    endcase
  endfunction

  // The watchdog is live only when enabled and a real period is chosen.
  function automatic logic wd_live(input logic en, input logic [1:0] sel);
    return en && (wd_sel_e'(sel) != WD_SEL_OFF);
  endfunction

  // True when the count about to be stored would reach the limit.
  function automatic logic wd_expired(input logic [31:0] count, input logic [31:0] limit);
    return (count + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync (
  input  logic clk_i,
  input  logic pwr_ok_i,
  input  logic kick_i,
  output logic fall_o
);
  logic s_meta, s_sync, s_prev;

  always_ff @(posedge clk_i) begin
    if (!pwr_ok_i) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= kick_i;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign fall_o = s_prev & ~s_sync;

  AST_FALL_IS_PULSE: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 31_250_000
) (
  input  logic clk_i,
  input  logic pwr_ok_i,
  input  logic restart_i,
  output logic busy_o
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYCLES);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (!pwr_ok_i || restart_i) cnt <= '0;
    else if (busy_o)            cnt <= cnt + 1'b1;
  end

  assign busy_o = (cnt != HOLD_END);

  AST_LOW_SUPPLY_REARMS: assert property (@(posedge clk_i)
    !pwr_ok_i |=> busy_o && (cnt == '0)); // R2
  AST_HOLD_STEPS: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    busy_o && !restart_i |=> cnt == $past(cnt) + 1'b1); // R2
  AST_TIMEOUT_REARMS: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    restart_i |=> busy_o); // R6
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer import supv_pkg::*; #(
  parameter int unsigned CW = 28
) (
  input  logic        clk_i,
  input  logic        pwr_ok_i,
  input  logic        run_i,
  input  logic        kick_i,
  input  logic [31:0] limit_i,
  output logic        bite_o
);
  logic [CW-1:0] cnt;
  logic          expire;

  assign expire = wd_expired(32'(cnt), limit_i);
  assign bite_o = run_i & ~kick_i & expire;

  always_ff @(posedge clk_i) begin
    if (!run_i || kick_i || expire) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  AST_KICK_RESTARTS: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    run_i && kick_i |=> cnt == '0); // R3
  AST_IDLE_CLEARED: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    !run_i |=> cnt == '0); // R8
  AST_COUNT_ADVANCES: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    run_i && !kick_i && !bite_o |=> cnt == $past(cnt) + 1'b1); // R5
  AST_KICK_BEATS_EXPIRY: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    kick_i |-> !bite_o); // R9
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen import supv_pkg::*; #(
  parameter int unsigned HOLD_CYCLES = 31_250_000,
  parameter int unsigned WD_CYC_0    = 175_000_000,
  parameter int unsigned WD_CYC_1    = 75_000_000,
  parameter int unsigned WD_CYC_2    = 25_000_000
) (
  input  logic       clk_i,
  input  logic       pwr_ok_i,
  input  logic       kick_i,
  input  logic       wd_en_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_n_o
);
  localparam int unsigned WD_MAX = max3(WD_CYC_0, WD_CYC_1, WD_CYC_2);
  localparam int unsigned CW     = $clog2(WD_MAX + 1);

  logic        kick_fall;
  logic        hold_busy;
  logic        wd_run;
  logic        wd_bite;
  logic [31:0] wd_limit;

  supv_kick_sync u_sync (
    .clk_i    (clk_i),
    .pwr_ok_i (pwr_ok_i),
    .kick_i   (kick_i),
    .fall_o   (kick_fall)
  );

  supv_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i     (clk_i),
    .pwr_ok_i  (pwr_ok_i),
    .restart_i (wd_bite),
    .busy_o    (hold_busy)
  );

  assign wd_limit = period_for(wd_sel_i, WD_CYC_0, WD_CYC_1, WD_CYC_2);
  assign wd_run   = pwr_ok_i & ~hold_busy & wd_live(wd_en_i, wd_sel_i);

  supv_wd_timer #(.CW(CW)) u_wd (
    .clk_i    (clk_i),
    .pwr_ok_i (pwr_ok_i),
    .run_i    (wd_run),
    .kick_i   (kick_fall),
    .limit_i  (wd_limit),
    .bite_o   (wd_bite)
  );

  assign rst_n_o = pwr_ok_i & ~hold_busy;

  AST_LOW_SUPPLY_RESET: assert property (@(posedge clk_i)
    !pwr_ok_i |=> !rst_n_o); // R1
  AST_BITE_ASSERTS_RESET: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    wd_bite |=> !rst_n_o); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    (!wd_en_i || wd_sel_i == 2'b11) |-> !wd_bite); // R7
  AST_NO_BITE_IN_RESET: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
    !rst_n_o |-> !wd_bite); // R8
endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb_top;
  localparam int HOLD = 20;
  localparam int P0 = 30, P1 = 45, P2 = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       pwr_ok = 1'b0;
  logic       kick   = 1'b1;
  logic       wd_en  = 1'b0;
  logic [1:0] wd_sel = 2'b00;
  logic       rst_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  supv_reset_gen #(.HOLD_CYCLES(HOLD), .WD_CYC_0(P0), .WD_CYC_1(P1), .WD_CYC_2(P2)) dut_i (
    .clk_i(clk), .pwr_ok_i(pwr_ok), .kick_i(kick), .wd_en_i(wd_en),
    .wd_sel_i(wd_sel), .rst_n_o(rst_n)
  );

  // Period chosen by a select code per R4; 0 means off.
  function automatic int sel_period(input logic [1:0] s);
    if (s == 2'b00) return P0;
    if (s == 2'b01) return P1;
    if (s == 2'b10) return P2;
    return 0;
  endfunction

  // Bench model: remaining hold edges, edges since last restart, kick history.
  int       m_hold = HOLD;
  int       m_idle = 0;
  logic [2:0] m_kh = 3'b111;

  always @(posedge clk) begin
    bit fell, live, bite;
    fell = m_kh[2] && !m_kh[1];
    live = pwr_ok && (m_hold == 0) && wd_en && (sel_period(wd_sel) > 0);
    bite = live && !fell && (m_idle + 1 >= sel_period(wd_sel));
    if (!pwr_ok)          m_hold = HOLD;
    else if (bite)        m_hold = HOLD;
    else if (m_hold > 0)  m_hold = m_hold - 1;
    if (!live || fell || bite) m_idle = 0;
    else                       m_idle = m_idle + 1;
    m_kh = pwr_ok ? {m_kh[1:0], kick} : 3'b111;
  end

  task automatic check_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rst_n_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: value %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R1 R2 R5 R6).
  always @(negedge clk) begin
    if (!done) begin
      if (!pwr_ok)         check_bit(rst_n, 1'b0, "R1");
      else if (m_hold > 0) check_bit(rst_n, 1'b0, "R2");
      else                 check_bit(rst_n, 1'b1, "R5");
    end
  end

  task automatic drive_slot();
    @(negedge clk);
    #1;
  endtask

  // Rising edges until rst_n reaches level (sampled after each negedge).
  task automatic edges_until(input logic level, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rst_n === level) break;
    end
  endtask

  task automatic power_cycle(input logic en, input logic [1:0] sel, input logic k);
    drive_slot();
    pwr_ok = 1'b0; wd_en = en; wd_sel = sel; kick = k;
    repeat (3) drive_slot();
    pwr_ok = 1'b1;
  endtask

  int n;
  int lows;

  initial begin
    // R1: reset state with supply low
    repeat (4) @(negedge clk);
    check_bit(rst_n, 1'b0, "R1");

    // R2: hold length after power-up, watchdog off
    drive_slot();
    pwr_ok = 1'b1;
    edges_until(1'b1, 1000, n);
    check_int(n, HOLD, "R2");

    // R7: disabled by enable bit, then by select code 2'b11 (R4)
    lows = 0;
    repeat (200) begin @(negedge clk); if (!rst_n) lows++; end
    check_int(lows, 0, "R7");
    drive_slot(); wd_en = 1'b1; wd_sel = 2'b11;
    lows = 0;
    repeat (200) begin @(negedge clk); if (!rst_n) lows++; end
    check_int(lows, 0, "R4");

    // R5/R4: each period, kick held high
    for (int s = 0; s < 3; s++) begin
      power_cycle(1'b1, 2'(s), 1'b1);
      edges_until(1'b1, 1000, n);
      check_int(n, HOLD, "R2");
      edges_until(1'b0, 1000, n);
      check_int(n, sel_period(2'(s)), "R5");
    end

    // R5: kick held low; R6: hold after timeout and resumed counting
    power_cycle(1'b1, 2'b00, 1'b0);
    edges_until(1'b1, 1000, n);
    edges_until(1'b0, 1000, n);
    check_int(n, P0, "R5");
    edges_until(1'b1, 1000, n);
    check_int(n, HOLD, "R6");
    edges_until(1'b0, 1000, n);
    check_int(n, P0, "R6");

    // R8: a kick during the timeout hold does not postpone the next timeout
    drive_slot(); kick = 1'b1;
    repeat (6) drive_slot();
    kick = 1'b0;
    edges_until(1'b1, 1000, n);
    edges_until(1'b0, 1000, n);
    check_int(n, P0, "R8");

    // R3: regular kicks keep reset released
    power_cycle(1'b1, 2'b00, 1'b1);
    edges_until(1'b1, 1000, n);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      repeat (10) drive_slot();
      kick = ~kick;
      if (!rst_n) lows++;
    end
    check_int(lows, 0, "R3");

    // R9: restart lands on the expiry edge
    power_cycle(1'b1, 2'b00, 1'b1);
    edges_until(1'b1, 1000, n);
    repeat (P0 - 3) @(posedge clk);
    drive_slot(); kick = 1'b0;
    edges_until(1'b0, 1000, n);
    check_int(n, P0 + 3, "R9");
    // one cycle late: expiry first
    power_cycle(1'b1, 2'b00, 1'b1);
    edges_until(1'b1, 1000, n);
    repeat (P0 - 2) @(posedge clk);
    drive_slot(); kick = 1'b0;
    edges_until(1'b0, 1000, n);
    check_int(n, 2, "R9");

    // R10: switch to a shorter period already passed
    power_cycle(1'b1, 2'b10, 1'b1);
    edges_until(1'b1, 1000, n);
    repeat (50) @(posedge clk);
    drive_slot(); wd_sel = 2'b00;
    edges_until(1'b0, 1000, n);
    check_int(n, 1, "R10");

    // R2: supply drop in mid-hold restarts the hold
    power_cycle(1'b1, 2'b11, 1'b1);
    repeat (8) drive_slot();
    pwr_ok = 1'b0;
    drive_slot();
    pwr_ok = 1'b1;
    edges_until(1'b1, 1000, n);
    check_int(n, HOLD, "R2");

    // Random phase against the model
    void'($urandom(32'd20240611));
    for (int c = 0; c < 30000; c++) begin
      drive_slot();
      if ($urandom_range(7) == 0) kick = ~kick;
      if ($urandom_range(199) == 0) wd_sel = 2'($urandom_range(3));
      if ($urandom_range(399) == 0) wd_en = ~wd_en;
      if ($urandom_range(1499) == 0) pwr_ok = 1'b0;
      else if (!pwr_ok && $urandom_range(2) == 0) pwr_ok = 1'b1;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule